// File: doc/BRIEF.md
# Reverb Work-Area Address Generator

This block turns reverb tap offsets into absolute word addresses inside a circular work area of a 1M-word sample memory. It holds the area's start and end registers, which software programs through 16-bit word writes, and a free-running clock counter. Half of that counter is the current buffer position.

A requester presents a tap request made of an offset for each channel, a channel select, a tap kind and an all-pass size. It holds the request until the block accepts it. The block derives the effective offset, which is the plain offset, the offset minus one, the offset minus the size, or the other channel's offset. It adds the buffer position and reduces the sum modulo the area length with a bit-serial divider. It then returns start plus the remainder as a single-cycle response.

When the programmed start is not below the end, the area is treated as switched off. Requests are then answered at once with an "off" flag and a zero address, and the reverb engine outputs silence.

Top module: `rvb_addr_gen`

## Requirements
- R1: After reset the (core-0 variant) area runs from 0xEFFF8 to 0xEFFFF (8 words), `req_ready` is 1 and `rsp_valid` is 0.
- R2: For an enabled area the response address is start + (((cycle >> 1) + eff) mod L), where L = end - start + 1 and eff is the effective offset, truncated to 20 bits.
- R3: The cycle counter clears at reset and counts every clock. The value used is the one present at the accepting edge, so the buffer position advances once every two clocks.
- R4: The modulo is a true modulo, so sums that are negative or large (32-bit signed offsets) still give an address in the range start to end.
- R5: `req_kind` selects the effective offset from the selected channel's offset (`req_ch` 0 = left/`req_off_l`, 1 = right/`req_off_r`): 0 gives it unchanged, 1 gives it minus one, 2 gives it minus `req_size`. The arithmetic is 32-bit two's complement.
- R6: `req_kind` 3 takes the other channel's offset unchanged: a right-channel request uses `req_off_l` and a left-channel request uses `req_off_r`.
- R7: On `wr_en`, `wr_sel` 0 loads start[19:16] from `wr_data[3:0]` and `wr_sel` 1 loads start[15:0] from `wr_data`. `wr_sel` 2 loads end[19:16] from `wr_data[3:0]`, and end[15:0] always reads as 0xFFFF. Data bits above bit 3 are ignored on the high-word writes, and `wr_sel` 3 changes nothing.
- R8: If start >= end at acceptance, the response comes one cycle after the accepting edge with `rsp_off` = 1 and `rsp_addr` = 0.
- R9: A request is accepted on an edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 until that request's single response, which arrives within 34 cycles. The area registers are sampled at acceptance, so later writes do not affect it.
- R10: Every response with `rsp_off` = 0 lies in the start to end range sampled at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Area register write strobe |
| wr_sel | input | 2 | Write target: 0 start high, 1 start low, 2 end high, 3 none |
| wr_data | input | 16 | Write data word |
| req_valid | input | 1 | Tap request valid, held until accepted |
| req_ready | output | 1 | Block idle, request will be accepted |
| req_kind | input | 2 | 0 direct, 1 minus one, 2 minus size, 3 other channel |
| req_ch | input | 1 | 0 left, 1 right |
| req_off_l | input | 32 | Left-channel signed tap offset |
| req_off_r | input | 32 | Right-channel signed tap offset |
| req_size | input | 32 | Signed all-pass size |
| rsp_valid | output | 1 | Single-cycle response strobe |
| rsp_addr | output | 20 | Wrapped absolute word address |
| rsp_off | output | 1 | Area disabled (start >= end) |

## Verification
Plain offsets are sent in the 8-word reset area, where wrapping happens every few positions and an error in the position counter shows up at once. Large positive offsets, negative offsets and the most negative 32-bit offset are sent in a large area and in a 16-word area, which separates a true modulo from a truncating or unsigned one. Each tap kind is sent on both channels with distinct left and right offsets, which exposes a swapped or missing channel selection and a wrong one or size subtraction. Register writes with junk upper bits, writes that should do nothing, writes made while a request is pending, and areas whose start equals or passes the end test the register decode, the snapshot and the disable boundary.

// File: rtl/rvb_pkg.sv
package rvb_pkg;
  localparam int unsigned HALF_W = 16;

  typedef enum logic [1:0] {
    TAP_DIRECT  = 2'd0,
    TAP_PREV    = 2'd1,
    TAP_ALLPASS = 2'd2,
    TAP_CROSS   = 2'd3
  } tap_kind_e;

  typedef enum logic [1:0] {
    WR_START_HI = 2'd0,
    WR_START_LO = 2'd1,
    WR_END_HI   = 2'd2,
    WR_NONE     = 2'd3
  } wr_sel_e;
endpackage

// File: rtl/rvb_area_regs.sv
module rvb_area_regs
  import rvb_pkg::*;
#(
  parameter int unsigned ADDR_W   = 20,
  parameter int unsigned CORE_SEL = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [HALF_W-1:0] wr_data,
  output logic [ADDR_W-1:0] start_o,
  output logic [ADDR_W-1:0] end_o,
  output logic [ADDR_W:0]   len_o,
  output logic              area_on_o
);
  localparam int unsigned HI_W  = ADDR_W - HALF_W;
  localparam int unsigned LEN_W = ADDR_W + 1;
  localparam logic [HI_W-1:0] RST_HI = (CORE_SEL != 0) ? {HI_W{1'b1}}
                                                       : {{(HI_W-1){1'b1}}, 1'b0};
  localparam logic [HALF_W-1:0] RST_LO = {{(HALF_W-3){1'b1}}, 3'b000};

  logic [ADDR_W-1:0] start_q;
  logic [HI_W-1:0]   end_hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q  <= {RST_HI, RST_LO};
      end_hi_q <= RST_HI;
    end else if (wr_en) begin
      case (wr_sel_e'(wr_sel))
        WR_START_HI: start_q[ADDR_W-1:HALF_W] <= wr_data[HI_W-1:0];
        WR_START_LO: start_q[HALF_W-1:0]      <= wr_data;
        WR_END_HI:   end_hi_q                 <= wr_data[HI_W-1:0];
        default:     ;
      endcase
    end
  end

  assign start_o   = start_q;
  assign end_o     = {end_hi_q, {HALF_W{1'b1}}};
  assign area_on_o = start_q < end_o;
  assign len_o     = {1'b0, end_o} - {1'b0, start_q} + LEN_W'(1);

  assert_sel_none_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == WR_NONE) |=> ($stable(start_q) && $stable(end_hi_q)));

  assert_start_hi_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == WR_START_HI) |=>
      (start_q[ADDR_W-1:HALF_W] == $past(wr_data[HI_W-1:0]) &&
       $stable(start_q[HALF_W-1:0]) && $stable(end_hi_q)));
endmodule

// File: rtl/rvb_tap_sel.sv
module rvb_tap_sel
  import rvb_pkg::*;
#(
  parameter int unsigned OFF_W = 32
) (
  input  logic [1:0]              kind,
  input  logic                    ch,
  input  logic signed [OFF_W-1:0] off_l,
  input  logic signed [OFF_W-1:0] off_r,
  input  logic signed [OFF_W-1:0] size,
  output logic signed [OFF_W-1:0] off_o
);
  function automatic logic signed [OFF_W-1:0] derive_offset(
    input tap_kind_e               k,
    input logic                    right,
    input logic signed [OFF_W-1:0] l,
    input logic signed [OFF_W-1:0] r,
    input logic signed [OFF_W-1:0] sz
  );
    logic signed [OFF_W-1:0] own;
    own = right ? r : l;
    case (k)
      TAP_PREV:    return own - OFF_W'(1);
      TAP_ALLPASS: return own - sz;
      TAP_CROSS:   return right ? l : r;
      default:     return own;
    endcase
  endfunction

  assign off_o = derive_offset(tap_kind_e'(kind), ch, off_l, off_r, size);
endmodule

// File: rtl/rvb_mod_unit.sv
module rvb_mod_unit #(
  parameter int unsigned MAG_W = 33,
  parameter int unsigned LEN_W = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [MAG_W-1:0] mag,
  input  logic             neg,
  input  logic [LEN_W-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [LEN_W-1:0] rem
);
  localparam int unsigned CNT_BITS = $clog2(MAG_W);

  logic [MAG_W-1:0]    shreg_q;
  logic [LEN_W-1:0]    acc_q, div_q, rem_q;
  logic [CNT_BITS-1:0] cnt_q;
  logic                run_q, fix_q, neg_q, done_q;

  logic [LEN_W:0]   trial, trial_sub;
  logic             trial_ge;
  logic [LEN_W-1:0] step_val;

  assign trial     = {acc_q, shreg_q[MAG_W-1]};
  assign trial_sub = trial - {1'b0, div_q};
  assign trial_ge  = trial >= {1'b0, div_q};
  assign step_val  = trial_ge ? trial_sub[LEN_W-1:0] : trial[LEN_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      acc_q   <= '0;
      div_q   <= '0;
      rem_q   <= '0;
      cnt_q   <= '0;
      run_q   <= 1'b0;
      fix_q   <= 1'b0;
      neg_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go) begin
        shreg_q <= mag;
        acc_q   <= '0;
        div_q   <= divisor;
        neg_q   <= neg;
        cnt_q   <= CNT_BITS'(MAG_W - 1);
        run_q   <= 1'b1;
      end else if (run_q) begin
        shreg_q <= shreg_q << 1;
        acc_q   <= step_val;
        if (cnt_q == '0) begin
          run_q <= 1'b0;
          fix_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - CNT_BITS'(1);
        end
      end else if (fix_q) begin
        fix_q  <= 1'b0;
        done_q <= 1'b1;
        rem_q  <= (neg_q && acc_q != '0) ? div_q - acc_q : acc_q;
      end
    end
  end

  assign busy = run_q | fix_q;
  assign done = done_q;
  assign rem  = rem_q;

  assert_rem_below_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (rem_q < div_q));

  assert_go_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !(run_q || fix_q));

  assert_partial_below_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> (acc_q < div_q));
endmodule

// File: rtl/rvb_addr_gen.sv
module rvb_addr_gen
  import rvb_pkg::*;
#(
  parameter int unsigned ADDR_W   = 20,
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned OFF_W    = 32,
  parameter int unsigned CORE_SEL = 0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [1:0]              wr_sel,
  input  logic [15:0]             wr_data,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [1:0]              req_kind,
  input  logic                    req_ch,
  input  logic signed [OFF_W-1:0] req_off_l,
  input  logic signed [OFF_W-1:0] req_off_r,
  input  logic signed [OFF_W-1:0] req_size,
  output logic                    rsp_valid,
  output logic [ADDR_W-1:0]       rsp_addr,
  output logic                    rsp_off
);
  localparam int unsigned LEN_W = ADDR_W + 1;
  localparam int unsigned SUM_W = ((CNT_W > OFF_W) ? CNT_W : OFF_W) + 1;
  localparam int unsigned MAG_W = SUM_W;
  localparam int unsigned LAT_W = $clog2(MAG_W + 3);

  // area registers
  logic [ADDR_W-1:0] area_start, area_end;
  logic [LEN_W-1:0]  area_len;
  logic              area_on;

  rvb_area_regs #(.ADDR_W(ADDR_W), .CORE_SEL(CORE_SEL)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .start_o   (area_start),
    .end_o     (area_end),
    .len_o     (area_len),
    .area_on_o (area_on)
  );

  // effective tap offset
  logic signed [OFF_W-1:0] tap_off;

  rvb_tap_sel #(.OFF_W(OFF_W)) u_tap (
    .kind  (req_kind),
    .ch    (req_ch),
    .off_l (req_off_l),
    .off_r (req_off_r),
    .size  (req_size),
    .off_o (tap_off)
  );

  // free-running clock counter; half of it is the buffer position
  logic [CNT_W-1:0] cyc_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc_q <= '0;
    else        cyc_q <= cyc_q + CNT_W'(1);
  end

  logic signed [SUM_W-1:0] pos_s, off_s, sum_s;
  logic                    sum_neg;
  logic [MAG_W-1:0]        sum_mag;

  assign pos_s   = SUM_W'(cyc_q >> 1);
  assign off_s   = SUM_W'(tap_off);
  assign sum_s   = pos_s + off_s;
  assign sum_neg = sum_s[SUM_W-1];
  assign sum_mag = sum_neg ? -sum_s : sum_s;

  // handshake and snapshot
  logic              accept, mod_go;
  logic              busy_q, fast_q;
  logic [ADDR_W-1:0] snap_start, snap_end;
  logic [LAT_W-1:0]  lat_q;

  assign accept    = req_valid && req_ready;
  assign mod_go    = accept && area_on;
  assign req_ready = !busy_q;

  logic             mod_busy, mod_done;
  logic [LEN_W-1:0] mod_rem;

  rvb_mod_unit #(.MAG_W(MAG_W), .LEN_W(LEN_W)) u_mod (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (mod_go),
    .mag     (sum_mag),
    .neg     (sum_neg),
    .divisor (area_len),
    .busy    (mod_busy),
    .done    (mod_done),
    .rem     (mod_rem)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      fast_q     <= 1'b0;
      snap_start <= '0;
      snap_end   <= '0;
      lat_q      <= '0;
    end else begin
      fast_q <= accept && !area_on;
      if (accept) begin
        busy_q     <= 1'b1;
        snap_start <= area_start;
        snap_end   <= area_end;
        lat_q      <= '0;
      end else begin
        if (rsp_valid) busy_q <= 1'b0;
        if (busy_q)    lat_q  <= lat_q + LAT_W'(1);
      end
    end
  end

  logic [LEN_W-1:0] full_addr;
  assign full_addr = {1'b0, snap_start} + mod_rem;

  assign rsp_valid = fast_q | mod_done;
  assign rsp_off   = fast_q;
  assign rsp_addr  = mod_done ? full_addr[ADDR_W-1:0] : '0;

  assert_busy_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  assert_single_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_latency_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (lat_q <= LAT_W'(MAG_W + 1)));

  assert_rsp_only_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> busy_q);

  assert_off_fast_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !area_on) |=> (rsp_valid && rsp_off));

  assert_div_idle_on_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !mod_busy);

  assert_addr_in_area_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_off) |-> (rsp_addr >= snap_start && rsp_addr <= snap_end));

  assert_no_carry_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mod_done |-> !full_addr[LEN_W-1]);
endmodule

// File: tb/rvb_addr_gen_tb.sv
`timescale 1ns/1ps
module rvb_addr_gen_tb_top;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               wr_en = 1'b0;
  logic [1:0]         wr_sel = '0;
  logic [15:0]        wr_data = '0;
  logic               req_valid = 1'b0;
  logic               req_ready;
  logic [1:0]         req_kind = '0;
  logic               req_ch = 1'b0;
  logic signed [31:0] req_off_l = '0;
  logic signed [31:0] req_off_r = '0;
  logic signed [31:0] req_size = '0;
  logic               rsp_valid;
  logic [19:0]        rsp_addr;
  logic               rsp_off;

  always #2 clk = ~clk;

  rvb_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind), .req_ch(req_ch),
    .req_off_l(req_off_l), .req_off_r(req_off_r), .req_size(req_size),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_off(rsp_off)
  );

  int checks = 0;
  int errors = 0;
  int sent = 0;
  int got = 0;
  longint tb_cyc;
  logic [19:0] m_start = 20'hEFFF8;
  logic [3:0]  m_end_hi = 4'hE;

  typedef struct {
    logic [19:0] addr;
    logic        off;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always @(posedge clk or negedge rst_n)
    if (!rst_n) tb_cyc <= 0;
    else        tb_cyc <= tb_cyc + 1;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int eff_off(input int kind, input bit ch, input int ol, input int orr, input int sz);
    int own;
    own = ch ? orr : ol;
    if (kind == 1) return own - 1;
    if (kind == 2) return own - sz;
    if (kind == 3) return ch ? ol : orr;
    return own;
  endfunction

  // scoreboard driver: push the expected response, then hold the request until accepted
  task automatic send(input int kind, input bit ch, input int ol, input int orr, input int sz,
                      input string tag);
    exp_t e;
    longint st, en, len, s, m;
    @(negedge clk);
    req_kind = 2'(kind); req_ch = ch; req_off_l = ol; req_off_r = orr; req_size = sz;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    st = longint'(m_start);
    en = longint'({m_end_hi, 16'hFFFF});
    e.tag = tag;
    if (st >= en) begin
      e.off = 1'b1; e.addr = '0;
    end else begin
      len = en - st + 1;
      s = (tb_cyc / 2) + longint'(eff_off(kind, ch, ol, orr, sz));
      m = s % len;
      if (m < 0) m = m + len;
      e.off = 1'b0; e.addr = 20'(st + m);
    end
    sb.push_back(e);
    sent++;
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R9 ready low after accept", req_ready, 0);
  endtask

  task automatic wr(input int sel, input logic [15:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'(sel); wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
    case (sel)
      0: m_start[19:16] = data[3:0];
      1: m_start[15:0]  = data;
      2: m_end_hi       = data[3:0];
      default: ;
    endcase
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      got++;
      if (sb.size() == 0) begin
        check(1'b0, "R9 unexpected response", rsp_addr, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(rsp_off == e.off, {e.tag, " off flag"}, rsp_off, e.off);
        check(rsp_addr == e.addr, {e.tag, " address"}, rsp_addr, e.addr);
      end
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd == 100000) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=<100000", wd);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R1 ready in reset", req_ready, 1);
    check(rsp_valid == 1'b0, "R1 no response in reset", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    check(rsp_valid == 1'b0, "R1 rsp idle after reset", rsp_valid, 0);

    // reset area, 8 words
    send(0, 0, 0, 0, 0, "R1 default area");
    send(0, 1, 99, 13, 0, "R2 right direct");
    send(0, 0, 7, 2, 0, "R2 left direct");

    // large area 0x10000..0x3FFFF, junk upper data bits ignored
    wr(0, 16'hFFF1);
    wr(1, 16'h0000);
    wr(2, 16'hABC3);
    send(0, 0, 100, 0, 0, "R7 programmed area");
    send(0, 0, 32'h7FFFFFF0, 0, 0, "R4 large positive");
    send(0, 0, -5, 0, 0, "R4 small negative");
    send(0, 1, 0, int'(32'h80000000), 0, "R4 most negative");
    send(1, 0, 50, 70, 0, "R5 prev left");
    send(1, 1, 50, 70, 0, "R5 prev right");
    send(2, 0, 50, 70, 40, "R5 allpass left");
    send(2, 1, 50, 70, 90, "R5 allpass right negative");
    send(3, 1, 11, 22, 0, "R6 cross right");
    send(3, 0, 11, 22, 0, "R6 cross left");
    send(0, 0, 0, 0, 0, "R3 position a");
    send(0, 0, 0, 0, 0, "R3 position b");
    @(negedge clk);
    send(0, 0, 0, 0, 0, "R3 position c");

    // 16-word area 0x2FFF0..0x2FFFF
    wr(0, 16'h0002);
    wr(1, 16'hFFF0);
    wr(2, 16'h0002);
    send(0, 0, 1000, 0, 0, "R2 small area");
    send(0, 1, 0, -1000, 0, "R4 small area negative");
    wr(3, 16'h0005);
    send(0, 0, 3, 0, 0, "R7 select 3 no effect");

    // writes while pending: request uses the old area
    send(0, 0, 21, 0, 0, "R9 snapshot");
    wr(0, 16'h0004);
    send(0, 0, 21, 0, 0, "R8 start above end");

    // start == end, then one word below
    wr(0, 16'h0003);
    wr(1, 16'hFFFF);
    wr(2, 16'h0003);
    send(0, 0, 4, 0, 0, "R8 start equals end");
    wr(1, 16'hFFFE);
    send(0, 0, 5, 0, 0, "R10 two-word area");
    send(0, 1, 0, -3, 0, "R10 two-word area negative");

    while (!req_ready || sb.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    check(got == sent, "R9 one response per request", got, sent);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule